// File: doc/BRIEF.md
# 1-Wire Slave ROM Command Sequencer

This block is the addressing layer of a 1-Wire slave. It sits above a time-slot engine. That engine reports three things: a detected bus reset (with a flag for a standard-length reset), every bit written by the master, and every read slot in which the slave must drive a bit. After each reset the block asks for a presence pulse. It then collects an 8-bit ROM command and runs that command against a 64-bit identity held as a parameter. The identity holds a family byte in bits 7:0, a 48-bit serial number in bits 55:8 and a check byte in bits 63:56.

When a command selects this slave, the block enters a hand-off state that gives the bus to the device-function layer. The block keeps two flags across transactions. The resume flag records that the last addressing command completed. The overdrive flag selects the fast slot timing in the slot engine.

Received bits arrive as a stream with rx_valid and are always accepted, so the block exerts no back-pressure on that stream. Transmitted bits leave as a valid/ready stream. While tx_valid is high, tx_bit stays constant until the slot engine takes it with tx_ready. A read slot that arrives while tx_valid is low finds no bit offered, and the slot engine leaves the line released.

Top module: `owr_rom_seq`

## Requirements
- R1: A cycle with rst_det high makes presence_req high for exactly the following cycle. The block then expects a fresh command byte, and this holds from any state, including part-way through a command byte.
- R2: Command bytes are received least significant bit first. A byte is complete after 8 accepted rx_valid bits.
- R3: Code 33h clears the resume flag and offers the 64 identity bits in order of bit index 0 to 63: family byte first, then the serial number, then the check byte, each least significant bit first. After the last bit is taken, fn_active goes high.
- R4: Code 55h clears the resume flag and compares 64 received bits, index 0 first, with the identity. A mismatch sends the block idle: fn_active stays low and later bits are ignored until a reset. A full match sets the resume flag and fn_active.
- R5: Code F0h clears the resume flag. For each index it offers the identity bit, then that bit's complement, then receives one direction bit. A direction bit unequal to the identity bit sends the block idle. Completing all 64 indices sets the resume flag and fn_active.
- R6: Code CCh clears the resume flag and raises fn_active on the next cycle.
- R7: Code A5h raises fn_active only when the resume flag is set. Otherwise the block goes idle with the flags unchanged.
- R8: Code 3Ch clears the resume flag, sets od_mode and raises fn_active.
- R9: Code 69h clears the resume flag and sets od_mode at once. It then performs the 64-bit comparison of R4 with the same outcomes.
- R10: A reset with rst_long high clears od_mode, and a reset with rst_long low keeps it. Any code other than the seven listed clears od_mode and sends the block idle.
- R11: tx_valid is high only while a bit is owed to the master. tx_bit does not change while tx_valid is high and tx_ready is low. rx_valid and tx_ready have no effect in states that do not use them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rst_det | input | 1 | One-cycle pulse: bus reset detected |
| rst_long | input | 1 | Qualifies rst_det: reset had standard length |
| rx_valid | input | 1 | A master-written bit is present |
| rx_bit | input | 1 | Value of the master-written bit |
| tx_ready | input | 1 | Slot engine takes the offered bit |
| tx_valid | output | 1 | A bit is offered for the next read slot |
| tx_bit | output | 1 | Offered bit value |
| presence_req | output | 1 | One-cycle request for a presence pulse |
| fn_active | output | 1 | Bus handed to the device-function layer |
| od_mode | output | 1 | Overdrive flag |
| resume_flag | output | 1 | Resume flag |

## Verification
The hardest state to reach from the ports is a Resume that succeeds. It needs the resume flag left set by an earlier, completed 64-bit match or search, then a fresh reset and the A5h code. The bench reaches it by running a full match of the identity first and then issuing Resume. It also runs a match that fails at bit 5 followed by Resume, to show that the flag was cleared at command entry. A reset that lands part-way through a command byte is reached by sending four bits, resetting, and then sending a whole Skip code, which only succeeds if the bit count restarted.

// File: rtl/owr_pkg.sv
package owr_pkg;

  localparam int CMD_BITS = 8;

  localparam logic [CMD_BITS-1:0] CODE_READ     = 8'h33;
  localparam logic [CMD_BITS-1:0] CODE_MATCH    = 8'h55;
  localparam logic [CMD_BITS-1:0] CODE_SEARCH   = 8'hF0;
  localparam logic [CMD_BITS-1:0] CODE_SKIP     = 8'hCC;
  localparam logic [CMD_BITS-1:0] CODE_OD_MATCH = 8'h69;
  localparam logic [CMD_BITS-1:0] CODE_RESUME   = 8'hA5;
  localparam logic [CMD_BITS-1:0] CODE_OD_SKIP  = 8'h3C;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_READ, ST_MATCH,
    ST_S_TRUE, ST_S_CMPL, ST_S_DIR, ST_FUNC
  } owr_state_e;

  typedef enum logic [2:0] {
    OP_READ, OP_MATCH, OP_SEARCH, OP_SKIP,
    OP_OD_MATCH, OP_RESUME, OP_OD_SKIP, OP_BAD
  } owr_op_e;

endpackage

// File: rtl/owr_cmd_decode.sv
module owr_cmd_decode
  import owr_pkg::*;
(
  input  logic [CMD_BITS-1:0] code,
  output owr_op_e             op
);
  always_comb begin
    case (code)
      CODE_READ:     op = OP_READ;
      CODE_MATCH:    op = OP_MATCH;
      CODE_SEARCH:   op = OP_SEARCH;
      CODE_SKIP:     op = OP_SKIP;
      CODE_OD_MATCH: op = OP_OD_MATCH;
      CODE_RESUME:   op = OP_RESUME;
      CODE_OD_SKIP:  op = OP_OD_SKIP;
      default:       op = OP_BAD;
    endcase
  end
endmodule

// File: rtl/owr_rom_bitsel.sv
module owr_rom_bitsel #(
  parameter int          ROM_BITS = 64,
  parameter logic [63:0] ROM_ID   = 64'h0,
  localparam int         IDX_W    = $clog2(ROM_BITS)
) (
  input  logic [IDX_W-1:0] idx,
  output logic             rom_bit
);
  logic [ROM_BITS-1:0] rom_q;
  assign rom_q   = ROM_ID[ROM_BITS-1:0];
  assign rom_bit = rom_q[idx];
endmodule

// File: rtl/owr_rom_seq.sv
module owr_rom_seq
  import owr_pkg::*;
#(
  parameter int          ROM_BITS = 64,
  parameter logic [63:0] ROM_ID   = 64'hB4_5A3C96E1F00F_26
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_det,
  input  logic rst_long,
  input  logic rx_valid,
  input  logic rx_bit,
  input  logic tx_ready,
  output logic tx_valid,
  output logic tx_bit,
  output logic presence_req,
  output logic fn_active,
  output logic od_mode,
  output logic resume_flag
);
  localparam int IDX_W = $clog2(ROM_BITS);
  localparam int CW    = $clog2(CMD_BITS);

  owr_state_e          state;
  logic [IDX_W-1:0]    idx;
  logic [CW-1:0]       ccnt;
  logic [CMD_BITS-2:0] cmd_sr;
  logic [CMD_BITS-1:0] cmd_next;
  logic                rc_q, od_q, pres_q;
  logic                rom_bit, idx_last, cmd_last;
  owr_op_e             op;

  assign cmd_next = {rx_bit, cmd_sr};
  assign cmd_last = (ccnt == CW'(CMD_BITS - 1));
  assign idx_last = (idx == IDX_W'(ROM_BITS - 1));

  owr_cmd_decode u_dec (.code(cmd_next), .op(op));

  owr_rom_bitsel #(.ROM_BITS(ROM_BITS), .ROM_ID(ROM_ID)) u_rom (
    .idx(idx), .rom_bit(rom_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      idx    <= '0;
      ccnt   <= '0;
      cmd_sr <= '0;
      rc_q   <= 1'b0;
      od_q   <= 1'b0;
      pres_q <= 1'b0;
    end else begin
      pres_q <= rst_det;
      if (rst_det) begin
        state <= ST_CMD;
        ccnt  <= '0;
        idx   <= '0;
        if (rst_long) od_q <= 1'b0;
      end else begin
        case (state)
          ST_CMD: if (rx_valid) begin
            cmd_sr <= cmd_next[CMD_BITS-1:1];
            if (cmd_last) begin
              idx <= '0;
              case (op)
                OP_READ:     begin rc_q <= 1'b0; state <= ST_READ;   end
                OP_MATCH:    begin rc_q <= 1'b0; state <= ST_MATCH;  end
                OP_SEARCH:   begin rc_q <= 1'b0; state <= ST_S_TRUE; end
                OP_SKIP:     begin rc_q <= 1'b0; state <= ST_FUNC;   end
                OP_OD_MATCH: begin rc_q <= 1'b0; od_q <= 1'b1; state <= ST_MATCH; end
                OP_OD_SKIP:  begin rc_q <= 1'b0; od_q <= 1'b1; state <= ST_FUNC;  end
                OP_RESUME:   state <= rc_q ? ST_FUNC : ST_IDLE;
                default:     begin od_q <= 1'b0; state <= ST_IDLE; end
              endcase
            end else begin
              ccnt <= ccnt + 1'b1;
            end
          end
          ST_READ: if (tx_ready) begin
            if (idx_last) state <= ST_FUNC;
            else          idx   <= idx + 1'b1;
          end
          ST_MATCH: if (rx_valid) begin
            if (rx_bit != rom_bit) state <= ST_IDLE;
            else if (idx_last) begin
              rc_q  <= 1'b1;
              state <= ST_FUNC;
            end else idx <= idx + 1'b1;
          end
          ST_S_TRUE: if (tx_ready) state <= ST_S_CMPL;
          ST_S_CMPL: if (tx_ready) state <= ST_S_DIR;
          ST_S_DIR: if (rx_valid) begin
            if (rx_bit != rom_bit) state <= ST_IDLE;
            else if (idx_last) begin
              rc_q  <= 1'b1;
              state <= ST_FUNC;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_S_TRUE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    tx_valid = 1'b0;
    tx_bit   = 1'b0;
    case (state)
      ST_READ, ST_S_TRUE: begin tx_valid = 1'b1; tx_bit = rom_bit;  end
      ST_S_CMPL:          begin tx_valid = 1'b1; tx_bit = ~rom_bit; end
      default: ;
    endcase
  end

  assign presence_req = pres_q;
  assign fn_active    = (state == ST_FUNC);
  assign od_mode      = od_q;
  assign resume_flag  = rc_q;

  AST_PRESENCE_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    rst_det |=> presence_req); // R1
  AST_MATCH_MISS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MATCH && rx_valid && !rst_det && rx_bit != rom_bit) |=> (state == ST_IDLE && !fn_active)); // R4
  AST_RESUME_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CMD && rx_valid && !rst_det && cmd_last && op == OP_RESUME && !rc_q) |=> !fn_active); // R7
  AST_OD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CMD && rx_valid && !rst_det && cmd_last && (op == OP_OD_SKIP || op == OP_OD_MATCH)) |=> od_mode); // R8
  AST_LONG_RST_OD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_det && rst_long) |=> !od_mode); // R10
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !rst_det) |=> (tx_valid && $stable(tx_bit))); // R11

endmodule

// File: tb/owr_rom_seq_tb.sv
module owr_rom_seq_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [63:0] ID = 64'hB4_5A3C96E1F00F_26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_det = 0, rst_long = 0, rx_valid = 0, rx_bit = 0, tx_ready = 0;
  logic tx_valid, tx_bit, presence_req, fn_active, od_mode, resume_flag;
  int   checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  owr_rom_seq #(.ROM_BITS(64), .ROM_ID(ID)) dut_i (
    .clk(clk), .rst_n(rst_n), .rst_det(rst_det), .rst_long(rst_long),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .presence_req(presence_req),
    .fn_active(fn_active), .od_mode(od_mode), .resume_flag(resume_flag)
  );

  // {rst_long, code[7:0], exp fn_active, exp od_mode, exp resume_flag}
  localparam logic [11:0] VEC [7] = '{
    {1'b1, 8'hCC, 3'b100},   // R6
    {1'b1, 8'hA5, 3'b000},   // R7
    {1'b1, 8'h3C, 3'b110},   // R8
    {1'b0, 8'h12, 3'b000},   // R10 unknown clears od
    {1'b1, 8'h3C, 3'b110},   // R8
    {1'b0, 8'hCC, 3'b110},   // R10 short reset keeps od
    {1'b1, 8'hFF, 3'b000}    // R10
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_reset(input logic lng);
    rst_det = 1; rst_long = lng; tick(); rst_det = 0; rst_long = 0;
    chk(presence_req == 1'b1, "R1", "presence after reset", presence_req, 1);
  endtask

  task automatic send_bit(input logic b);
    rx_valid = 1; rx_bit = b; tick(); rx_valid = 0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic take_bit(output logic b, output logic v);
    b = tx_bit; v = tx_valid; tx_ready = 1; tick(); tx_ready = 0;
  endtask

  task automatic flags(input string req, input logic f, input logic o, input logic r);
    chk(fn_active == f, req, "fn_active", fn_active, f);
    chk(od_mode == o, req, "od_mode", od_mode, o);
    chk(resume_flag == r, req, "resume_flag", resume_flag, r);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic b, v, c, cv;
    logic [63:0] acc;
    int bad;
    tick(); tick(); rst_n = 1; tick();
    // reset state
    chk(presence_req == 0, "R1", "idle presence", presence_req, 0);
    chk(tx_valid == 0, "R11", "idle tx_valid", tx_valid, 0);
    flags("R1", 0, 0, 0);

    for (int k = 0; k < 7; k++) begin
      bus_reset(VEC[k][11]);
      send_byte(VEC[k][10:3]);
      tick();
      flags(k == 1 ? "R7" : (k == 2 || k == 4) ? "R8" : (k == 0) ? "R6" : "R10",
            VEC[k][2], VEC[k][1], VEC[k][0]);
    end

    // R4 full match
    bus_reset(1); send_byte(8'h55);
    for (int i = 0; i < 64; i++) send_bit(ID[i]);
    flags("R4", 1, 0, 1);
    // R7 resume succeeds
    bus_reset(1); send_byte(8'hA5); tick();
    flags("R7", 1, 0, 1);
    // R4 mismatch at bit 5, later bits ignored
    bus_reset(1); send_byte(8'h55);
    for (int i = 0; i < 6; i++) send_bit(i == 5 ? ~ID[i] : ID[i]);
    for (int i = 6; i < 64; i++) send_bit(ID[i]);
    flags("R4", 0, 0, 0);
    // R7 resume refused after failed match
    bus_reset(1); send_byte(8'hA5); tick();
    flags("R7", 0, 0, 0);

    // R3 / R2 read, with stall check R11
    bus_reset(1); send_byte(8'h33);
    b = tx_bit;
    tick(); tick(); tick();
    chk(tx_valid == 1 && tx_bit == b, "R11", "held under stall", {tx_valid, tx_bit}, {1'b1, b});
    acc = '0; bad = 0;
    for (int i = 0; i < 64; i++) begin
      take_bit(b, v);
      acc[i] = b;
      if (!v) bad++;
    end
    chk(acc == ID, "R3", "read identity (R2 lsb first)", acc, ID);
    chk(bad == 0, "R11", "tx_valid during read", bad, 0);
    chk(tx_valid == 0, "R11", "tx_valid after read", tx_valid, 0);
    flags("R3", 1, 0, 0);

    // R5 full search
    bus_reset(1); send_byte(8'hF0);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      take_bit(b, v); take_bit(c, cv);
      if (!v || !cv || b != ID[i] || c != ~ID[i]) bad++;
      send_bit(ID[i]);
    end
    chk(bad == 0, "R5", "search true/complement errors", bad, 0);
    flags("R5", 1, 0, 1);
    // R5 search drop-out
    bus_reset(1); send_byte(8'hF0);
    take_bit(b, v); take_bit(c, cv);
    send_bit(~ID[0]);
    chk(tx_valid == 0, "R5", "no offer after drop", tx_valid, 0);
    send_bit(ID[1]); tx_ready = 1; tick(); tx_ready = 0;
    flags("R5", 0, 0, 0);

    // R9 overdrive match
    bus_reset(1); send_byte(8'h69);
    chk(od_mode == 1, "R9", "od set at entry", od_mode, 1);
    for (int i = 0; i < 64; i++) send_bit(ID[i]);
    flags("R9", 1, 1, 1);
    bus_reset(1);
    chk(od_mode == 0, "R10", "long reset clears od", od_mode, 0);

    // R1 reset mid-command restarts byte count
    send_bit(1); send_bit(1); send_bit(0); send_bit(0);
    bus_reset(1); send_byte(8'hCC); tick();
    flags("R1", 1, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule